// File: doc/BRIEF.md
# Second-Level Interrupt Aggregator

This block gathers up to 32 interrupt sources into one request line for a parent interrupt controller. Each source owns one bit position in every register. Software reaches the block through a simple word-addressed register port: a write strobe, a read strobe, an address and a data word. A read returns its data one cycle later, marked by a valid pulse.

A build-time parameter picks one of two variants:
- **Latched (edge) variant.** A rising edge on a source sets a sticky pending bit. Software acknowledges it by writing a 1 to the matching bit of a clear register. A separate set register lets software force pending bits for testing.
- **Level variant.** The status word is the live level of the inputs, and there is no clear register.

In both variants, masking is changed only through a write-1-to-mask register and a write-1-to-unmask register. A read-only mask status register returns the current mask. The parent request is raised while any status bit is 1 and not masked.

Two small state machines shape the timing:
- **Read path.** The read-path machine sits in `RD_IDLE`. It moves to `RD_RESP` on the *read accepted* transition, which is a read strobe. It stays in `RD_RESP` on back-to-back reads. It returns to `RD_IDLE` on the *response retired* transition, which is a cycle without a read strobe. `reg_rvalid` is high exactly in `RD_RESP`.
- **Request path.** The request machine sits in `REQ_IDLE` and takes the *raise* transition to `REQ_ACTIVE` when an unmasked status bit exists. It takes the *drop* transition back to `REQ_IDLE` when none remains. `irq_out` is high exactly in `REQ_ACTIVE`, so the request is registered.

Top module: `intc_l2_top`

## Requirements
- R1: After reset the mask is all ones (every source masked), every latched pending bit is 0, `irq_out` is 0 and `reg_rvalid` is 0.
- R2: A write to the mask-set register (offset 0x10 in the edge variant, 0x08 in the level variant) sets each mask bit whose data bit is 1. Bits written 0 keep their previous value.
- R3: A write to the mask-clear register (offset 0x14 in the edge variant, 0x0C in the level variant) clears each mask bit whose data bit is 1. Bits written 0 keep their previous value.
- R4: A read of the mask status register (offset 0x0C in the edge variant, 0x04 in the level variant) returns the current mask, with 1 meaning masked.
- R5: In the edge variant, a source that is 0 in one clock and 1 at the next rising clock edge sets its pending bit at that edge. The bit stays set after the source returns to 0. Pending bits are read at offset 0x00.
- R6: In the edge variant, writing to the clear register at offset 0x08 clears each pending bit whose data bit is 1 and leaves the others alone; writing all ones clears every bit. If a new edge on a bit arrives in the same cycle as a clear of that bit, the bit stays set.
- R7: In the edge variant, writing to the set register at offset 0x04 sets each pending bit whose data bit is 1.
- R8: In the level variant, the status word at offset 0x00 equals the input levels sampled at the read. It has no clear or set register, so offsets 0x10 and 0x14 are unmapped there.
- R9: `irq_out` equals, one cycle later, whether any bit of (status AND NOT mask) is 1. A pending bit latched at an edge therefore raises `irq_out` one edge later, and unmasking it raises `irq_out` at the second edge after the write.
- R10: Reads of write-only or unmapped offsets return 0. Writes to the status and mask status registers, and to unmapped offsets, change nothing.
- R11: A read strobe sampled at one clock edge makes `reg_rvalid` high, with the read data, after that edge. `reg_rvalid` is low after any edge without a read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W (8) | Byte offset of the register |
| reg_wdata | input | NUM_SRC (32) | Write data |
| reg_rdata | output | NUM_SRC (32) | Read data, valid with `reg_rvalid` |
| reg_rvalid | output | 1 | Read data valid, one cycle after the read strobe |
| irq_src | input | NUM_SRC (32) | Interrupt source inputs, one bit per source |
| irq_out | output | 1 | Registered request to the parent controller |

## Verification
Single sources are pulsed while they are masked and then while unmasked. This separates latching from forwarding: the status register must change in both cases, while `irq_out` changes only in the second. Set and clear words that mix 1s and 0s show that zero bits are left untouched. A clear that lands in the same cycle as a fresh edge on one bit, while also clearing another bit, shows that the new event survives and the acknowledge still works. On the level variant the inputs are moved up and down between reads, which shows that its status follows the inputs and is not latched. Writes to the offsets that only the edge variant uses show that they decode to nothing there.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int unsigned DEF_NUM_SRC = 32;
    localparam int unsigned DEF_ADDR_W  = 8;

    // Latched variant register map
    localparam logic [7:0] EDGE_OFS_STATUS = 8'h00;
    localparam logic [7:0] EDGE_OFS_PSET   = 8'h04;
    localparam logic [7:0] EDGE_OFS_PCLR   = 8'h08;
    localparam logic [7:0] EDGE_OFS_MSTAT  = 8'h0C;
    localparam logic [7:0] EDGE_OFS_MSET   = 8'h10;
    localparam logic [7:0] EDGE_OFS_MCLR   = 8'h14;

    // Level variant register map
    localparam logic [7:0] LVL_OFS_STATUS  = 8'h00;
    localparam logic [7:0] LVL_OFS_MSTAT   = 8'h04;
    localparam logic [7:0] LVL_OFS_MSET    = 8'h08;
    localparam logic [7:0] LVL_OFS_MCLR    = 8'h0C;

    typedef enum logic {
        RD_IDLE = 1'b0,
        RD_RESP = 1'b1
    } rd_state_e;

    typedef enum logic {
        REQ_IDLE   = 1'b0,
        REQ_ACTIVE = 1'b1
    } req_state_e;

endpackage

// File: rtl/intc_regdec.sv
module intc_regdec
    import intc_pkg::*;
#(
    parameter int unsigned NUM_SRC   = DEF_NUM_SRC,
    parameter int unsigned ADDR_W    = DEF_ADDR_W,
    parameter bit          EDGE_MODE = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_i,
    input  logic               rd_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [NUM_SRC-1:0] status_i,
    input  logic [NUM_SRC-1:0] mask_i,
    output logic               pset_stb_o,
    output logic               pclr_stb_o,
    output logic               mset_stb_o,
    output logic               mclr_stb_o,
    output logic [NUM_SRC-1:0] rdata_o,
    output logic               rvalid_o
);

    localparam logic [ADDR_W-1:0] OFS_STATUS = ADDR_W'(EDGE_MODE ? EDGE_OFS_STATUS : LVL_OFS_STATUS);
    localparam logic [ADDR_W-1:0] OFS_MSTAT  = ADDR_W'(EDGE_MODE ? EDGE_OFS_MSTAT  : LVL_OFS_MSTAT);
    localparam logic [ADDR_W-1:0] OFS_MSET   = ADDR_W'(EDGE_MODE ? EDGE_OFS_MSET   : LVL_OFS_MSET);
    localparam logic [ADDR_W-1:0] OFS_MCLR   = ADDR_W'(EDGE_MODE ? EDGE_OFS_MCLR   : LVL_OFS_MCLR);
    localparam logic [ADDR_W-1:0] OFS_PSET   = ADDR_W'(EDGE_OFS_PSET);
    localparam logic [ADDR_W-1:0] OFS_PCLR   = ADDR_W'(EDGE_OFS_PCLR);

    rd_state_e          rd_state_q, rd_state_d;
    logic [NUM_SRC-1:0] rd_mux;
    logic [NUM_SRC-1:0] rdata_q;

    // Write strobes: pending set/clear exist only in the latched variant
    generate
        if (EDGE_MODE) begin : g_edge_dec
            assign pset_stb_o = wr_i && (addr_i == OFS_PSET);
            assign pclr_stb_o = wr_i && (addr_i == OFS_PCLR);
        end else begin : g_lvl_dec
            assign pset_stb_o = 1'b0;
            assign pclr_stb_o = 1'b0;
        end
    endgenerate

    assign mset_stb_o = wr_i && (addr_i == OFS_MSET);
    assign mclr_stb_o = wr_i && (addr_i == OFS_MCLR);

    // Read multiplexer: only the two readable registers return data
    always_comb begin
        rd_mux = '0;
        if (addr_i == OFS_STATUS) begin
            rd_mux = status_i;
        end else if (addr_i == OFS_MSTAT) begin
            rd_mux = mask_i;
        end
    end

    // Read-path state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_state_q <= RD_IDLE;
        end else begin
            rd_state_q <= rd_state_d;
        end
    end

    // Read-path next state
    always_comb begin
        rd_state_d = rd_state_q;
        unique case (rd_state_q)
            RD_IDLE: if (rd_i)  rd_state_d = RD_RESP;   // read accepted
            RD_RESP: if (!rd_i) rd_state_d = RD_IDLE;   // response retired
            default: rd_state_d = RD_IDLE;
        endcase
    end

    // Read data capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_i) begin
            rdata_q <= rd_mux;
        end
    end

    // Outputs
    always_comb begin
        rvalid_o = (rd_state_q == RD_RESP);
        rdata_o  = rdata_q;
    end

    AST_RD_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_i |=> rvalid_o);   // R11
    AST_RD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> !rvalid_o); // R11
    AST_ONE_WR_STB: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pset_stb_o, pclr_stb_o, mset_stb_o, mclr_stb_o})); // R10

endmodule

// File: rtl/intc_mask_reg.sv
module intc_mask_reg
    import intc_pkg::*;
#(
    parameter int unsigned NUM_SRC = DEF_NUM_SRC
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_stb_i,
    input  logic               clr_stb_i,
    input  logic [NUM_SRC-1:0] wdata_i,
    output logic [NUM_SRC-1:0] mask_o
);

    logic [NUM_SRC-1:0] mask_q;

    // All sources start masked; writes of 1 set or clear, 0 bits hold
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '1;
        end else if (set_stb_i) begin
            mask_q <= mask_q | wdata_i;
        end else if (clr_stb_i) begin
            mask_q <= mask_q & ~wdata_i;
        end
    end

    assign mask_o = mask_q;

    AST_MASK_SET_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        set_stb_i |=> ((mask_o & $past(wdata_i)) == $past(wdata_i))); // R2
    AST_MASK_SET_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        set_stb_i |=> ((mask_o & ~$past(wdata_i)) == ($past(mask_o) & ~$past(wdata_i)))); // R2
    AST_MASK_CLR_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_stb_i && !set_stb_i |=> ((mask_o & $past(wdata_i)) == '0)); // R3
    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !set_stb_i && !clr_stb_i |=> $stable(mask_o)); // R10

endmodule

// File: rtl/intc_src_capture.sv
module intc_src_capture
    import intc_pkg::*;
#(
    parameter int unsigned NUM_SRC   = DEF_NUM_SRC,
    parameter bit          EDGE_MODE = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               pset_stb_i,
    input  logic               pclr_stb_i,
    input  logic [NUM_SRC-1:0] wdata_i,
    output logic [NUM_SRC-1:0] status_o
);

    generate
        if (EDGE_MODE) begin : g_latched
            logic [NUM_SRC-1:0] prev_q;
            logic [NUM_SRC-1:0] pend_q;
            logic [NUM_SRC-1:0] rise;
            logic [NUM_SRC-1:0] set_vec;
            logic [NUM_SRC-1:0] clr_vec;

            assign rise    = src_i & ~prev_q;
            assign set_vec = pset_stb_i ? wdata_i : '0;
            assign clr_vec = pclr_stb_i ? wdata_i : '0;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    prev_q <= '0;
                    pend_q <= '0;
                end else begin
                    prev_q <= src_i;
                    // A fresh edge wins over a clear of the same bit
                    pend_q <= (pend_q & ~clr_vec) | rise | set_vec;
                end
            end

            assign status_o = pend_q;

            AST_EDGE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
                (rise != '0) |=> ((status_o & $past(rise)) == $past(rise))); // R5 R6
            AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
                pclr_stb_i |=> ((status_o & $past(wdata_i & ~rise)) == '0)); // R6
            AST_PSET_BITS: assert property (@(posedge clk) disable iff (!rst_n)
                pset_stb_i |=> ((status_o & $past(wdata_i)) == $past(wdata_i))); // R7
            AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
                !pclr_stb_i |=> ((status_o & $past(status_o)) == $past(status_o))); // R5
        end else begin : g_level
            logic unused_lvl;
            assign unused_lvl = ^{clk, rst_n, pset_stb_i, pclr_stb_i, wdata_i};
            assign status_o   = src_i;
        end
    endgenerate

endmodule

// File: rtl/intc_req_fsm.sv
module intc_req_fsm
    import intc_pkg::*;
#(
    parameter int unsigned NUM_SRC = DEF_NUM_SRC
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] status_i,
    input  logic [NUM_SRC-1:0] mask_i,
    output logic               req_o
);

    req_state_e req_q, req_d;
    logic       any_live;

    assign any_live = |(status_i & ~mask_i);

    // Request state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q <= REQ_IDLE;
        end else begin
            req_q <= req_d;
        end
    end

    // Request next state
    always_comb begin
        req_d = req_q;
        unique case (req_q)
            REQ_IDLE:   if (any_live)  req_d = REQ_ACTIVE; // raise
            REQ_ACTIVE: if (!any_live) req_d = REQ_IDLE;   // drop
            default:    req_d = REQ_IDLE;
        endcase
    end

    // Output
    always_comb begin
        req_o = (req_q == REQ_ACTIVE);
    end

    AST_REQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (req_o == $past(any_live))); // R9
    AST_REQ_MASKED_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_i == '1) |=> !req_o); // R9

endmodule

// File: rtl/intc_l2_top.sv
module intc_l2_top
    import intc_pkg::*;
#(
    parameter int unsigned NUM_SRC   = DEF_NUM_SRC,
    parameter int unsigned ADDR_W    = DEF_ADDR_W,
    parameter bit          EDGE_MODE = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [NUM_SRC-1:0] reg_wdata,
    output logic [NUM_SRC-1:0] reg_rdata,
    output logic               reg_rvalid,
    input  logic [NUM_SRC-1:0] irq_src,
    output logic               irq_out
);

    logic [NUM_SRC-1:0] status;
    logic [NUM_SRC-1:0] mask;
    logic               pset_stb;
    logic               pclr_stb;
    logic               mset_stb;
    logic               mclr_stb;

    intc_regdec #(
        .NUM_SRC   (NUM_SRC),
        .ADDR_W    (ADDR_W),
        .EDGE_MODE (EDGE_MODE)
    ) u_regdec (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (reg_wr),
        .rd_i       (reg_rd),
        .addr_i     (reg_addr),
        .status_i   (status),
        .mask_i     (mask),
        .pset_stb_o (pset_stb),
        .pclr_stb_o (pclr_stb),
        .mset_stb_o (mset_stb),
        .mclr_stb_o (mclr_stb),
        .rdata_o    (reg_rdata),
        .rvalid_o   (reg_rvalid)
    );

    intc_mask_reg #(
        .NUM_SRC (NUM_SRC)
    ) u_mask (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_stb_i (mset_stb),
        .clr_stb_i (mclr_stb),
        .wdata_i   (reg_wdata),
        .mask_o    (mask)
    );

    intc_src_capture #(
        .NUM_SRC   (NUM_SRC),
        .EDGE_MODE (EDGE_MODE)
    ) u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_i      (irq_src),
        .pset_stb_i (pset_stb),
        .pclr_stb_i (pclr_stb),
        .wdata_i    (reg_wdata),
        .status_o   (status)
    );

    intc_req_fsm #(
        .NUM_SRC (NUM_SRC)
    ) u_req (
        .clk      (clk),
        .rst_n    (rst_n),
        .status_i (status),
        .mask_i   (mask),
        .req_o    (irq_out)
    );

    AST_RESET_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (mask == '1)); // R1

endmodule

// File: tb/intc_l2_top_bench.sv
module intc_l2_top_bench;

    localparam int unsigned NS = 32;
    localparam int unsigned AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;

    // latched-variant bus
    logic          e_wr = 0, e_rd = 0;
    logic [AW-1:0] e_addr = '0;
    logic [NS-1:0] e_wdata = '0, e_src = '0;
    logic [NS-1:0] e_rdata;
    logic          e_rvalid, e_irq;

    // level-variant bus
    logic          l_wr = 0, l_rd = 0;
    logic [AW-1:0] l_addr = '0;
    logic [NS-1:0] l_wdata = '0, l_src = '0;
    logic [NS-1:0] l_rdata;
    logic          l_rvalid, l_irq;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    logic [NS-1:0] exp_e_q[$];
    string         tag_e_q[$];
    logic [NS-1:0] exp_l_q[$];
    string         tag_l_q[$];

    always #10 clk = ~clk;

    intc_l2_top #(.NUM_SRC(NS), .ADDR_W(AW), .EDGE_MODE(1'b1)) u_intc_l2_top (
        .clk(clk), .rst_n(rst_n), .reg_wr(e_wr), .reg_rd(e_rd), .reg_addr(e_addr),
        .reg_wdata(e_wdata), .reg_rdata(e_rdata), .reg_rvalid(e_rvalid),
        .irq_src(e_src), .irq_out(e_irq));

    intc_l2_top #(.NUM_SRC(NS), .ADDR_W(AW), .EDGE_MODE(1'b0)) u_intc_l2_top_lvl (
        .clk(clk), .rst_n(rst_n), .reg_wr(l_wr), .reg_rd(l_rd), .reg_addr(l_addr),
        .reg_wdata(l_wdata), .reg_rdata(l_rdata), .reg_rvalid(l_rvalid),
        .irq_src(l_src), .irq_out(l_irq));

    task automatic check_val(input logic [NS-1:0] act, input logic [NS-1:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pops expected read data as responses appear
    always @(negedge clk) begin
        if (rst_n && e_rvalid) begin
            if (exp_e_q.size() == 0) check_val(e_rdata, 'x, "R11 unexpected edge response");
            else check_val(e_rdata, exp_e_q.pop_front(), tag_e_q.pop_front());
        end
        if (rst_n && l_rvalid) begin
            if (exp_l_q.size() == 0) check_val(l_rdata, 'x, "R11 unexpected level response");
            else check_val(l_rdata, exp_l_q.pop_front(), tag_l_q.pop_front());
        end
    end

    // Driver tasks
    task automatic wr_e(input logic [AW-1:0] a, input logic [NS-1:0] d);
        @(negedge clk); e_wr = 1; e_addr = a; e_wdata = d;
        @(negedge clk); e_wr = 0;
    endtask
    task automatic wr_l(input logic [AW-1:0] a, input logic [NS-1:0] d);
        @(negedge clk); l_wr = 1; l_addr = a; l_wdata = d;
        @(negedge clk); l_wr = 0;
    endtask
    task automatic rd_e(input logic [AW-1:0] a, input logic [NS-1:0] exp, input string tag);
        @(negedge clk); exp_e_q.push_back(exp); tag_e_q.push_back(tag); e_rd = 1; e_addr = a;
        @(negedge clk); e_rd = 0;
    endtask
    task automatic rd_l(input logic [AW-1:0] a, input logic [NS-1:0] exp, input string tag);
        @(negedge clk); exp_l_q.push_back(exp); tag_l_q.push_back(tag); l_rd = 1; l_addr = a;
        @(negedge clk); l_rd = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        check_val(NS'(e_irq), '0, "R1 edge irq after reset");
        check_val(NS'(l_irq), '0, "R1 level irq after reset");
        check_val(NS'(e_rvalid), '0, "R1 rvalid after reset");
        rd_e(8'h0C, 32'hFFFF_FFFF, "R1 R4 edge mask after reset");
        rd_e(8'h00, 32'h0, "R1 edge pending after reset");
        rd_l(8'h04, 32'hFFFF_FFFF, "R1 R4 level mask after reset");

        // R5: masked edge latches, stays after source falls
        @(negedge clk); e_src[5] = 1;
        @(negedge clk); e_src[5] = 0;
        rd_e(8'h00, 32'h0000_0020, "R5 latched edge");
        check_val(NS'(e_irq), '0, "R9 masked pending keeps irq low");

        // R3/R9: unmask, exact request timing
        @(negedge clk); e_wr = 1; e_addr = 8'h14; e_wdata = 32'h20;
        @(negedge clk); e_wr = 0;
        check_val(NS'(e_irq), '0, "R9 irq one edge after unmask");
        @(negedge clk);
        check_val(NS'(e_irq), 32'h1, "R9 irq two edges after unmask");
        rd_e(8'h0C, 32'hFFFF_FFDF, "R3 R4 mask after clear");

        // R2: remask, request drops
        wr_e(8'h10, 32'h20);
        @(negedge clk);
        check_val(NS'(e_irq), '0, "R9 irq drops after remask");
        wr_e(8'h14, 32'h0000_FF00);
        wr_e(8'h10, 32'h0000_0100);
        rd_e(8'h0C, 32'hFFFF_01FF, "R2 R3 zero bits keep mask");

        // R7: set register forces pending
        wr_e(8'h04, 32'h8000_0001);
        rd_e(8'h00, 32'h8000_0021, "R7 forced pending");

        // R6: clear only the 1 bits
        wr_e(8'h08, 32'h0000_0001);
        rd_e(8'h00, 32'h8000_0020, "R6 partial clear");

        // R6: edge in same cycle as clear of that bit
        @(negedge clk); e_src[3] = 1; e_wr = 1; e_addr = 8'h08; e_wdata = 32'h8000_0008;
        @(negedge clk); e_wr = 0;
        rd_e(8'h00, 32'h0000_0028, "R6 edge beats clear");

        // R6: clear all while source still high gives no new edge
        wr_e(8'h08, 32'hFFFF_FFFF);
        rd_e(8'h00, 32'h0, "R6 clear all");
        @(negedge clk); e_src[3] = 0;

        // R10: read-only writes ignored, write-only reads zero
        wr_e(8'h00, 32'hFFFF_FFFF);
        rd_e(8'h00, 32'h0, "R10 status write ignored");
        wr_e(8'h0C, 32'h0);
        rd_e(8'h0C, 32'hFFFF_01FF, "R10 mask status write ignored");
        rd_e(8'h04, 32'h0, "R10 set reg reads zero");
        rd_e(8'h08, 32'h0, "R10 clear reg reads zero");
        rd_e(8'h10, 32'h0, "R10 mask set reads zero");
        rd_e(8'h14, 32'h0, "R10 mask clear reads zero");
        rd_e(8'h18, 32'h0, "R10 unmapped reads zero");
        @(negedge clk);
        check_val(NS'(e_rvalid), '0, "R11 no response without read");

        // Level variant
        @(negedge clk); l_src = 32'h0000_0050;
        rd_l(8'h00, 32'h0000_0050, "R8 level status live");
        @(negedge clk); l_src = 32'h0000_0010;
        rd_l(8'h00, 32'h0000_0010, "R8 level status follows fall");
        wr_l(8'h10, 32'h0);
        wr_l(8'h14, 32'hFFFF_FFFF);
        rd_l(8'h04, 32'hFFFF_FFFF, "R8 R10 edge-only offsets unmapped");
        check_val(NS'(l_irq), '0, "R9 level masked irq low");
        wr_l(8'h0C, 32'h0000_0010);
        @(negedge clk);
        check_val(NS'(l_irq), 32'h1, "R9 level irq after unmask");
        rd_l(8'h04, 32'hFFFF_FFEF, "R3 R4 level mask clear");
        @(negedge clk); l_src = 32'h0;
        @(negedge clk);
        check_val(NS'(l_irq), '0, "R9 level irq follows input fall");
        wr_l(8'h08, 32'h0000_0010);
        rd_l(8'h04, 32'hFFFF_FFFF, "R2 level mask set");
        rd_l(8'h08, 32'h0, "R10 level write-only reads zero");
        wr_l(8'h00, 32'hFFFF_FFFF);
        rd_l(8'h00, 32'h0, "R10 level status write ignored");

        repeat (3) @(negedge clk);
        check_val(32'(exp_e_q.size() + exp_l_q.size()), '0, "R11 outstanding responses");
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule